// File: doc/BRIEF.md
# Display Memory Write Address Sequencer

This block produces the write address for a display memory built as a stack of byte-wide banks, each bank holding one byte per column. A host first positions the pointer with set-column and set-bank commands, then streams data bytes. Each accepted data byte is written at the current address and the pointer then moves one step on its own, so that an image can be loaded with no further addressing.

The step order can be row-first (the column moves, then the bank) or column-first (the bank moves, then the column). Two programmable carriage-return limits mark the last column and the last bank of the active window. When the pointer passes a limit it returns to zero, so a window smaller than the array is filled repeatedly. A mirror mode reflects the column that reaches the memory, so the image appears flipped left to right, while the internal order of the pointer is unchanged.

Top module: `disp_addr_gen`

## Requirements
- R1: After reset the pointer is at bank 0, column 0, the step order is row-first and mirroring is off, so `bank_o` = 0 and `col_o` = 0.
- R2: `mem_we_o` is high in exactly those cycles where `data_valid_i` is high and no command input is high; in that cycle `bank_o`/`col_o` give the address being written.
- R3: In row-first order (`mode_vert_i` = 0 when loaded), each write moves the column up by one; a write at the column limit sets the column to 0 and moves the bank up by one.
- R4: In row-first order, a write at both the column limit and the bank limit sets both column and bank to 0.
- R5: In column-first order (`mode_vert_i` = 1), each write moves the bank up by one; a write at the bank limit sets the bank to 0 and moves the column up by one, or sets it to 0 when it is also at the column limit.
- R6: The bank limit in use is `ylim_i` clamped to NUM_BANKS-1 (12 by default); the column limit is `xlim_i` clamped to NUM_COLS-1.
- R7: `setx_i` loads the column with `setx_val_i` and `sety_i` loads the bank with `sety_val_i`, each clamped to the limit in use; neither changes the other coordinate.
- R8: With mirroring on (`mode_mirror_i` = 1 when loaded), `col_o` = NUM_COLS-1 minus the internal column, and the stepping sequence is unchanged.
- R9: A data strobe in the same cycle as any command (`setx_i`, `sety_i`, `mode_we_i`) is ignored: no write, and only the command takes effect.
- R10: Without a data strobe or a set command the pointer holds; loading new mode bits does not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Load the mode bits below |
| mode_vert_i | input | 1 | Step order: 0 row-first, 1 column-first |
| mode_mirror_i | input | 1 | 1 mirrors the column sent to memory |
| xlim_i | input | 7 | Column carriage-return limit (last column of the window) |
| ylim_i | input | 4 | Bank carriage-return limit (last bank of the window) |
| setx_i | input | 1 | Set-column command |
| setx_val_i | input | 7 | Column value for set-column |
| sety_i | input | 1 | Set-bank command |
| sety_val_i | input | 4 | Bank value for set-bank |
| data_valid_i | input | 1 | Data byte strobe |
| bank_o | output | 4 | Current write bank |
| col_o | output | 7 | Current write column as seen by the memory |
| mem_we_o | output | 1 | Memory write enable |

## Verification
The stepping properties take for granted that the carriage-return limits do not move below the pointer while bytes stream; a limit lowered under the pointer is handled by returning to zero, but the single-step checks would not cover it. The bench keeps to this: it changes limits and mode only between sweeps and repositions the pointer with set commands before each one. The command-priority property relies on a command and a data strobe in the same cycle meaning a command byte, which the bench drives on purpose once.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;
  typedef enum logic {
    ADV_ROW_FIRST = 1'b0,
    ADV_COL_FIRST = 1'b1
  } adv_order_e;
endpackage

// File: rtl/dag_limit_clamp.sv
module dag_limit_clamp #(
  parameter int W    = 4,
  parameter int MAXV = 12
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lim_o
);
  localparam logic [W-1:0] MaxL = W'(MAXV);
  always_comb lim_o = (raw_i > MaxL) ? MaxL : raw_i;
endmodule

// File: rtl/dag_step.sv
module dag_step
  import disp_addr_pkg::*;
#(
  parameter int COL_W  = 7,
  parameter int BANK_W = 4
) (
  input  adv_order_e        order_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  xlim_i,
  input  logic [BANK_W-1:0] ylim_i,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o
);
  logic col_end, bank_end;
  logic [COL_W-1:0]  col_inc;
  logic [BANK_W-1:0] bank_inc;

  // >= so a limit lowered under the pointer still wraps
  assign col_end  = (col_i >= xlim_i);
  assign bank_end = (bank_i >= ylim_i);
  assign col_inc  = col_i + COL_W'(1);
  assign bank_inc = bank_i + BANK_W'(1);

  always_comb begin
    col_o  = col_i;
    bank_o = bank_i;
    if (order_i == ADV_ROW_FIRST) begin
      if (col_end) begin
        col_o  = '0;
        bank_o = bank_end ? '0 : bank_inc;
      end else begin
        col_o = col_inc;
      end
    end else begin
      if (bank_end) begin
        bank_o = '0;
        col_o  = col_end ? '0 : col_inc;
      end else begin
        bank_o = bank_inc;
      end
    end
  end
endmodule

// File: rtl/dag_col_map.sv
module dag_col_map #(
  parameter int COL_W    = 7,
  parameter int NUM_COLS = 128
) (
  input  logic             mirror_i,
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o
);
  localparam logic [COL_W-1:0] LastCol = COL_W'(NUM_COLS - 1);
  always_comb col_o = mirror_i ? (LastCol - col_i) : col_i;
endmodule

// File: rtl/disp_addr_gen.sv
module disp_addr_gen
  import disp_addr_pkg::*;
#(
  parameter int NUM_BANKS = 13,
  parameter int NUM_COLS  = 128,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int COL_W    = $clog2(NUM_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic              mode_vert_i,
  input  logic              mode_mirror_i,
  input  logic [COL_W-1:0]  xlim_i,
  input  logic [BANK_W-1:0] ylim_i,
  input  logic              setx_i,
  input  logic [COL_W-1:0]  setx_val_i,
  input  logic              sety_i,
  input  logic [BANK_W-1:0] sety_val_i,
  input  logic              data_valid_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic              mem_we_o
);
  logic [COL_W-1:0]  col_q, col_nxt, x_eff, setx_cl;
  logic [BANK_W-1:0] bank_q, bank_nxt, y_eff, sety_cl;
  adv_order_e        order_q;
  logic              mirror_q;
  logic              cmd_any, wr;

  dag_limit_clamp #(.W(COL_W), .MAXV(NUM_COLS - 1)) u_xclamp (
    .raw_i(xlim_i), .lim_o(x_eff)
  );
  dag_limit_clamp #(.W(BANK_W), .MAXV(NUM_BANKS - 1)) u_yclamp (
    .raw_i(ylim_i), .lim_o(y_eff)
  );

  dag_step #(.COL_W(COL_W), .BANK_W(BANK_W)) u_step (
    .order_i(order_q), .col_i(col_q), .bank_i(bank_q),
    .xlim_i(x_eff), .ylim_i(y_eff),
    .col_o(col_nxt), .bank_o(bank_nxt)
  );

  dag_col_map #(.COL_W(COL_W), .NUM_COLS(NUM_COLS)) u_map (
    .mirror_i(mirror_q), .col_i(col_q), .col_o(col_o)
  );

  assign setx_cl  = (setx_val_i > x_eff) ? x_eff : setx_val_i;
  assign sety_cl  = (sety_val_i > y_eff) ? y_eff : sety_val_i;
  assign cmd_any  = setx_i | sety_i | mode_we_i;
  assign wr       = data_valid_i & ~cmd_any;
  assign mem_we_o = wr;
  assign bank_o   = bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q    <= '0;
      bank_q   <= '0;
      order_q  <= ADV_ROW_FIRST;
      mirror_q <= 1'b0;
    end else if (cmd_any) begin
      if (setx_i) col_q <= setx_cl;
      if (sety_i) bank_q <= sety_cl;
      if (mode_we_i) begin
        order_q  <= mode_vert_i ? ADV_COL_FIRST : ADV_ROW_FIRST;
        mirror_q <= mode_mirror_i;
      end
    end else if (wr) begin
      col_q  <= col_nxt;
      bank_q <= bank_nxt;
    end
  end
endmodule

// File: rtl/disp_addr_gen_chk.sv
module disp_addr_gen_chk #(
  parameter int NUM_BANKS = 13,
  parameter int NUM_COLS  = 128,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int COL_W    = $clog2(NUM_COLS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_we_i,
  input logic              setx_i,
  input logic              sety_i,
  input logic [BANK_W-1:0] sety_val_i,
  input logic              data_valid_i,
  input logic              mem_we_o,
  input logic [COL_W-1:0]  col_o,
  input logic [COL_W-1:0]  col_q,
  input logic [BANK_W-1:0] bank_q,
  input logic [COL_W-1:0]  x_eff,
  input logic [BANK_W-1:0] y_eff,
  input logic              vert_q,
  input logic              mirror_q
);
  localparam int LastCol = NUM_COLS - 1;

  assert_we_qual_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (data_valid_i && !setx_i && !sety_i && !mode_we_i));

  assert_we_given_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_i && !setx_i && !sety_i && !mode_we_i) |-> mem_we_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_valid_i && !setx_i && !sety_i) |=> ($stable(col_q) && $stable(bank_q)));

  assert_row_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !vert_q && col_q < x_eff) |=>
      (32'(col_q) == 32'($past(col_q)) + 1 && $stable(bank_q)));

  assert_col_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && vert_q && bank_q < y_eff) |=>
      (32'(bank_q) == 32'($past(bank_q)) + 1 && $stable(col_q)));

  assert_sety_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sety_i && sety_val_i <= y_eff) |=> (bank_q == $past(sety_val_i)));

  assert_ylim_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(y_eff) <= NUM_BANKS - 1);

  assert_mirror_map_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mirror_q |-> (32'(col_o) + 32'(col_q) == LastCol));
endmodule

bind disp_addr_gen disp_addr_gen_chk #(.NUM_BANKS(NUM_BANKS), .NUM_COLS(NUM_COLS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .setx_i(setx_i),
  .sety_i(sety_i), .sety_val_i(sety_val_i), .data_valid_i(data_valid_i),
  .mem_we_o(mem_we_o), .col_o(col_o), .col_q(col_q), .bank_q(bank_q),
  .x_eff(x_eff), .y_eff(y_eff), .vert_q(order_q == disp_addr_pkg::ADV_COL_FIRST),
  .mirror_q(mirror_q)
);

// File: tb/sim_disp_addr_gen.sv
module sim_disp_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 13;
  localparam int NC = 128;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       mode_we = 0, mode_vert = 0, mode_mirror = 0;
  logic [6:0] xlim = 7'd127, setx_val = 0;
  logic [3:0] ylim = 4'd12, sety_val = 0;
  logic       setx = 0, sety = 0, dval = 0;
  logic [3:0] bank;
  logic [6:0] col;
  logic       we;

  int n_tests = 0, n_fail = 0;
  int ec = 0, eb = 0, exl = 127, eyl = 12;
  bit evert = 0, emir = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_vert_i(mode_vert),
    .mode_mirror_i(mode_mirror), .xlim_i(xlim), .ylim_i(ylim), .setx_i(setx),
    .setx_val_i(setx_val), .sety_i(sety), .sety_val_i(sety_val),
    .data_valid_i(dval), .bank_o(bank), .col_o(col), .mem_we_o(we)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ecol();
    return emir ? (NC - 1 - ec) : ec;
  endfunction

  task automatic set_limits(int xl, int yl);
    xlim = 7'(xl); ylim = 4'(yl);
    exl = xl; eyl = (yl > NB - 1) ? NB - 1 : yl;
  endtask

  task automatic load_mode(bit v, bit m);
    @(negedge clk);
    mode_we = 1; mode_vert = v; mode_mirror = m;
    @(posedge clk); #1 mode_we = 0;
    evert = v; emir = m;
  endtask

  task automatic set_pos(int x, int y);
    @(negedge clk);
    setx = 1; setx_val = 7'(x); sety = 1; sety_val = 4'(y);
    @(posedge clk); #1 setx = 0; sety = 0;
    ec = (x > exl) ? exl : x;
    eb = (y > eyl) ? eyl : y;
  endtask

  task automatic model_step();
    if (!evert) begin
      if (ec >= exl) begin ec = 0; eb = (eb >= eyl) ? 0 : eb + 1; end
      else ec++;
    end else begin
      if (eb >= eyl) begin eb = 0; ec = (ec >= exl) ? 0 : ec + 1; end
      else eb++;
    end
  endtask

  task automatic write_byte(string req);
    @(negedge clk);
    dval = 1;
    #1;
    check({req, " bank"}, int'(bank), eb);
    check({req, " col"}, int'(col), ecol());
    check("R2 we", int'(we), 1);
    @(posedge clk); #1 dval = 0;
    model_step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int xls[4] = '{0, 1, 4, 127};
    int yls[4] = '{0, 3, 12, 15};
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check("R1 bank", int'(bank), 0);
    check("R1 col", int'(col), 0);
    check("R1 we", int'(we), 0);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 col after release", int'(col), 0);

    // R1/R3: default row-first order after reset
    set_limits(127, 12);
    write_byte("R1 default order");
    write_byte("R3 row step");
    check("R3 col advanced", int'(col), 2);
    check("R3 bank held", int'(bank), 0);

    // R10: idle cycles and a mode load keep the pointer
    repeat (5) @(negedge clk);
    #1 check("R10 idle col", int'(col), 2);
    load_mode(0, 0);
    @(negedge clk); #1;
    check("R10 mode load col", int'(col), 2);
    check("R10 mode load bank", int'(bank), 0);

    // R3 R4 R5 R6 R8: sweeps over limits, order and mirroring
    for (int v = 0; v < 2; v++) begin
      for (int m = 0; m < 2; m++) begin
        load_mode(bit'(v), bit'(m));
        for (int i = 0; i < 4; i++) begin
          for (int j = 0; j < 4; j++) begin
            if (xls[i] == 127 && j >= 2 && m == 1) continue;
            set_limits(xls[i], yls[j]);
            set_pos(0, 0);
            for (int k = 0; k < (exl + 1) * (eyl + 1) + 2; k++)
              write_byte(v ? "R5 col-first sweep" : (m ? "R8 mirror sweep" : "R4 row-first sweep"));
          end
        end
      end
    end

    // R6: bank limit above array clamps to last bank
    load_mode(0, 0);
    set_limits(0, 15);
    set_pos(0, 12);
    write_byte("R6 at clamped limit");
    @(negedge clk); #1;
    check("R6 bank wrapped", int'(bank), 0);

    // R7: set commands clamp to limits and leave other coordinate
    set_limits(10, 5);
    set_pos(50, 9);
    @(negedge clk); #1;
    check("R7 col clamp", int'(col), 10);
    check("R7 bank clamp", int'(bank), 5);
    @(negedge clk);
    setx = 1; setx_val = 7'd3;
    @(posedge clk); #1 setx = 0;
    @(negedge clk); #1;
    check("R7 setx col", int'(col), 3);
    check("R7 setx bank kept", int'(bank), 5);
    ec = 3; eb = 5;

    // R9: data strobe together with a command is not a write
    @(negedge clk);
    dval = 1; sety = 1; sety_val = 4'd2;
    #1 check("R9 we blocked", int'(we), 0);
    @(posedge clk); #1 dval = 0; sety = 0;
    @(negedge clk); #1;
    check("R9 bank loaded", int'(bank), 2);
    check("R9 col not advanced", int'(col), 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule